// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block sits behind a CAN frame deserializer and decides which of a bank of mailboxes a finished frame is written into. In the cycle a completed frame is presented, every mailbox that is switched on and set to receive tests the frame's identifier against its own filter word. Each mailbox may also carry a per-bit mask. The highest-numbered mailbox that can take the frame wins, and the frame's identifier, length, remote flag and eight data bytes are written into that mailbox's storage.

Software sees the block through a simple register port. The port holds the enable, direction and overwrite-protection vectors, each mailbox's filter and mask words, the received contents, and two status vectors. One status vector marks mailboxes holding an unread frame. The other marks mailboxes whose unread frame was replaced. Both are cleared by writing ones. A pending mailbox with protection set is skipped, so the frame falls through to the next lower candidate. A pending mailbox without protection is overwritten, and the loss is recorded.

Top module: `can_rxmb_alloc`

## Requirements
- R1: After a synchronous active-low reset, every register (enable, direction, protection, pending, lost, filter, mask and all received contents) reads zero, and addresses outside the map read zero.
- R2: A mailbox can receive only if its enable bit and its direction bit are both 1. Direction 0 means transmit, and such a mailbox never receives.
- R3: Among the mailboxes able to take a frame, the highest-numbered one is chosen.
- R4: A filter word carries the extended-format flag in bit 31 and the mask-enable flag in bit 30. A standard 11-bit identifier sits in bits 28:18 and an extended 29-bit identifier in bits 28:0. The frame format must equal bit 31. For a standard frame, bits 17:0 are not compared.
- R5: When mask-enable is set, a mask bit of 1 makes the matching filter bit (bit 31 or 28:0) don't-care, and a 0 requires equality. An all-ones mask accepts any frame. Without mask-enable, the mask has no effect.
- R6: A stored frame is readable from the next cycle. The identifier word has bit 31 = extended, with the identifier placed as in R4. The control word has the remote flag in bit 4 and the DLC in bits 3:0. The low data word holds bytes 0..3 and the high data word holds bytes 4..7, with byte 0 in bits 31:24.
- R7: Storing a frame sets that mailbox's pending bit. Writing 1 to a pending bit clears it. If a clear and a new frame hit the same bit in one cycle, the bit ends set.
- R8: A mailbox that is pending and overwrite-protected is skipped, and its contents are kept. The frame goes to the next lower mailbox able to take it.
- R9: If the chosen mailbox is pending without protection, its contents are replaced and its lost bit is set. Lost bits clear by writing 1.
- R10: If no mailbox can take a frame, the frame is dropped and no pending, lost or content register changes.
- R11: Register map: the top address bit selects global (0) or mailbox (1). Global selects in bits 2:0 are 0 enable, 1 direction, 2 protection, 3 pending, 4 lost. Mailbox space uses {1, index, select}, where select 0 is filter, 1 is mask, 2 is received identifier, 3 is control, 4 is data low and 5 is data high. Configuration registers read back what was written. Writes to received-content registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: a completed frame is on the frame inputs |
| frm_ext | input | 1 | Frame uses the 29-bit identifier format |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Identifier (standard frames use bits 10:0) |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (9) | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
A frame or a register write sampled at one rising edge is visible on reg_rdata during the very next cycle, because the read path is combinational from the registers updated at that edge. The bench therefore drives inputs just after a rising edge and samples reg_rdata at the following falling edge. A behavioural reference model is updated at each rising edge from the same inputs and compared against whatever address is selected on every clock. Directed reads at the falling edge after each frame check the hand-computed placement, pending, lost and content values.

// File: rtl/can_rxmb_pkg.sv
// Shared types and encodings for the CAN receive mailbox allocator.
// Assumes identifiers arrive right-aligned (standard frames in bits 10:0).
package can_rxmb_pkg;

    // Completed frame as handed over by the deserializer
    typedef struct packed {
        logic        ext;
        logic        rtr;
        logic [28:0] id;
        logic [3:0]  dlc;
        logic [63:0] data;
    } rxf_t;

    // Global register selects (address bits 2:0, global space)
    typedef enum logic [2:0] {
        G_EN   = 3'd0,
        G_DIR  = 3'd1,
        G_PROT = 3'd2,
        G_PEND = 3'd3,
        G_LOST = 3'd4
    } gsel_e;

    // Per-mailbox register selects (address bits 2:0, mailbox space)
    typedef enum logic [2:0] {
        M_FILT = 3'd0,
        M_MASK = 3'd1,
        M_RID  = 3'd2,
        M_CTL  = 3'd3,
        M_DLO  = 3'd4,
        M_DHI  = 3'd5
    } msel_e;

    localparam int IDW_EXT = 31;
    localparam int IDW_AME = 30;

    // Place an identifier in the 32-bit identifier word layout
    function automatic logic [31:0] id_word(input logic ext, input logic [28:0] id);
        if (ext) id_word = {1'b1, 2'b00, id};
        else     id_word = {1'b0, 2'b00, id[10:0], 18'd0};
    endfunction

endpackage

// File: rtl/can_rxmb_filter.sv
// One mailbox's identifier filter: compares the frame against the filter
// word, honouring the per-bit mask only when mask-enable is set.
// Assumes a standard frame never compares identifier bits 17:0.
module can_rxmb_filter
    import can_rxmb_pkg::*;
(
    input  logic [31:0] filt_word,
    input  logic [31:0] mask_word,
    input  logic        f_ext,
    input  logic [28:0] f_id,
    output logic        hit
);

    logic [31:0] fw;
    logic [31:0] care;

    // Build the care vector and test the masked difference
    always_comb begin
        fw         = id_word(f_ext, f_id);
        care       = 32'hFFFF_FFFF;
        care[30:29] = 2'b00;
        if (filt_word[IDW_AME]) care = care & ~mask_word;
        if (!f_ext) care[17:0] = '0;
        hit = ((fw ^ filt_word) & care) == 32'd0;
    end

endmodule

// File: rtl/can_rxmb_pick.sv
// Chooses the destination mailbox: drops protected pending mailboxes from
// the eligible set and grants the highest-numbered remaining one.
// Assumes N is a power of two.
module can_rxmb_pick #(
    parameter  int N = 32,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] elig,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] prot,
    output logic [N-1:0] cand,
    output logic         any,
    output logic [W-1:0] idx,
    output logic         over
);

    // Highest-set-bit search over the candidate vector
    always_comb begin
        cand = elig & ~(pend & prot);
        any  = 1'b0;
        idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
        over = any & pend[idx];
    end

    // R3: nothing above the grant is a candidate
    p_highest_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((cand >> idx) == N'(1)));

    // R8: a protected pending mailbox is never granted
    p_prot_skipped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> !(pend[idx] && prot[idx]));

endmodule

// File: rtl/can_rxmb_cfg.sv
// Software-written configuration: enable, direction and protection vectors
// plus the filter and mask word of every mailbox.
// Assumes the top has already split the address into space, index, select.
module can_rxmb_cfg
    import can_rxmb_pkg::*;
#(
    parameter  int N = 32,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         is_mb,
    input  logic [2:0]   sel,
    input  logic [W-1:0] mb_idx,
    input  logic [31:0]  wdata,
    output logic [N-1:0] en,
    output logic [N-1:0] dir,
    output logic [N-1:0] prot,
    output logic [31:0]  filt [N],
    output logic [31:0]  mask [N]
);

    // Global configuration vectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            dir  <= '0;
            prot <= '0;
        end else if (we && !is_mb) begin
            case (sel)
                G_EN:    en   <= wdata[N-1:0];
                G_DIR:   dir  <= wdata[N-1:0];
                G_PROT:  prot <= wdata[N-1:0];
                default: ;
            endcase
        end
    end

    // Per-mailbox filter and mask words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                filt[i] <= '0;
                mask[i] <= '0;
            end
        end else if (we && is_mb) begin
            case (sel)
                M_FILT:  filt[mb_idx] <= wdata;
                M_MASK:  mask[mb_idx] <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/can_rxmb_store.sv
// Received-frame storage and the pending / lost status vectors.
// Assumes pend_clr and lost_clr are one-cycle write-one-to-clear masks;
// a same-cycle set always wins over a clear.
module can_rxmb_store
    import can_rxmb_pkg::*;
#(
    parameter  int N = 32,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         st_we,
    input  logic [W-1:0] st_idx,
    input  logic         st_over,
    input  rxf_t         frm,
    input  logic [N-1:0] pend_clr,
    input  logic [N-1:0] lost_clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] lost,
    output logic [31:0]  rid [N],
    output logic [4:0]   ctl [N],
    output logic [31:0]  dlo [N],
    output logic [31:0]  dhi [N]
);

    logic [N-1:0] set_vec;

    // One-hot of the mailbox being written this cycle
    always_comb set_vec = st_we ? (N'(1) << st_idx) : '0;

    // Pending and lost status update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            lost <= '0;
        end else begin
            pend <= (pend & ~pend_clr) | set_vec;
            lost <= (lost & ~lost_clr) | (st_over ? set_vec : '0);
        end
    end

    // Frame contents written into the chosen mailbox
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                rid[i] <= '0;
                ctl[i] <= '0;
                dlo[i] <= '0;
                dhi[i] <= '0;
            end
        end else if (st_we) begin
            rid[st_idx] <= id_word(frm.ext, frm.id);
            ctl[st_idx] <= {frm.rtr, frm.dlc};
            dlo[st_idx] <= frm.data[63:32];
            dhi[st_idx] <= frm.data[31:0];
        end
    end

    // R7: a stored frame leaves its mailbox pending
    p_pend_after_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> pend[$past(st_idx)]);

    // R9: an overwrite is only signalled for a mailbox already pending
    p_over_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_over) |-> pend[st_idx]);

    // R9: overwrite records the loss
    p_lost_on_over_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_over) |=> lost[$past(st_idx)]);

    // R9: a lost bit only rises after an overwrite
    p_lost_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((lost & ~$past(lost)) != '0) |-> $past(st_we && st_over));

endmodule

// File: rtl/can_rxmb_alloc.sv
// Top of the receive mailbox allocator: decodes the register port, runs
// one filter per mailbox, picks the destination and stores the frame.
// Assumes NUM_MBOX is a power of two no larger than 32 and that frm_valid
// is a single-cycle strobe per frame.
module can_rxmb_alloc
    import can_rxmb_pkg::*;
#(
    parameter  int NUM_MBOX = 32,
    localparam int MB_W     = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1,
    localparam int ADDR_W   = MB_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              frm_ext,
    input  logic              frm_rtr,
    input  logic [28:0]       frm_id,
    input  logic [3:0]        frm_dlc,
    input  logic [63:0]       frm_data,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    localparam int N = NUM_MBOX;

    logic            is_mb;
    logic [2:0]      sel;
    logic [MB_W-1:0] mb_idx;
    logic [N-1:0]    en, dir, prot, hit, elig, cand, pend, lost;
    logic [N-1:0]    pend_clr, lost_clr;
    logic [31:0]     filt [N];
    logic [31:0]     mask [N];
    logic [31:0]     rid  [N];
    logic [4:0]      ctl  [N];
    logic [31:0]     dlo  [N];
    logic [31:0]     dhi  [N];
    logic            any, over, st_we;
    logic [MB_W-1:0] st_idx;
    rxf_t            frm;

    // Address split and write-one-to-clear masks
    always_comb begin
        is_mb    = reg_addr[ADDR_W-1];
        sel      = reg_addr[2:0];
        mb_idx   = reg_addr[ADDR_W-2:3];
        pend_clr = (reg_we && !is_mb && sel == G_PEND) ? reg_wdata[N-1:0] : '0;
        lost_clr = (reg_we && !is_mb && sel == G_LOST) ? reg_wdata[N-1:0] : '0;
        frm      = '{ext: frm_ext, rtr: frm_rtr, id: frm_id, dlc: frm_dlc, data: frm_data};
    end

    can_rxmb_cfg #(.N(N)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .is_mb  (is_mb),
        .sel    (sel),
        .mb_idx (mb_idx),
        .wdata  (reg_wdata),
        .en     (en),
        .dir    (dir),
        .prot   (prot),
        .filt   (filt),
        .mask   (mask)
    );

    for (genvar g = 0; g < N; g++) begin : g_flt
        can_rxmb_filter u_flt (
            .filt_word (filt[g]),
            .mask_word (mask[g]),
            .f_ext     (frm_ext),
            .f_id      (frm_id),
            .hit       (hit[g])
        );
    end

    // Receive-capable mailboxes whose filter accepts the frame
    always_comb elig = en & dir & hit;

    can_rxmb_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .pend  (pend),
        .prot  (prot),
        .cand  (cand),
        .any   (any),
        .idx   (st_idx),
        .over  (over)
    );

    // Store only when a frame arrives and a destination exists
    always_comb st_we = frm_valid & any;

    can_rxmb_store #(.N(N)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_we    (st_we),
        .st_idx   (st_idx),
        .st_over  (over),
        .frm      (frm),
        .pend_clr (pend_clr),
        .lost_clr (lost_clr),
        .pend     (pend),
        .lost     (lost),
        .rid      (rid),
        .ctl      (ctl),
        .dlo      (dlo),
        .dhi      (dhi)
    );

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (!is_mb) begin
            case (sel)
                G_EN:    reg_rdata = 32'(en);
                G_DIR:   reg_rdata = 32'(dir);
                G_PROT:  reg_rdata = 32'(prot);
                G_PEND:  reg_rdata = 32'(pend);
                G_LOST:  reg_rdata = 32'(lost);
                default: reg_rdata = '0;
            endcase
        end else begin
            case (sel)
                M_FILT:  reg_rdata = filt[mb_idx];
                M_MASK:  reg_rdata = mask[mb_idx];
                M_RID:   reg_rdata = rid[mb_idx];
                M_CTL:   reg_rdata = 32'(ctl[mb_idx]);
                M_DLO:   reg_rdata = dlo[mb_idx];
                M_DHI:   reg_rdata = dhi[mb_idx];
                default: reg_rdata = '0;
            endcase
        end
    end

    // R2: only an enabled receive mailbox is ever written
    p_rx_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (en[st_idx] && dir[st_idx]));

    // R10: a dropped frame leaves the pending vector untouched
    p_drop_keeps_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !any && pend_clr == '0) |=> $stable(pend));

endmodule

// File: tb/can_rxmb_alloc_tb_top.sv
// Bench for can_rxmb_alloc: a behavioural reference model updated on each
// rising edge and compared on every falling edge, plus directed reads.
module can_rxmb_alloc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic        frm_ext = 1'b0;
    logic        frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_rxmb_alloc #(.NUM_MBOX(32)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_ext   (frm_ext),
        .frm_rtr   (frm_rtr),
        .frm_id    (frm_id),
        .frm_dlc   (frm_dlc),
        .frm_data  (frm_data),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_en, m_dir, m_prot, m_pend, m_lost;
    logic [31:0] m_filt [32];
    logic [31:0] m_mask [32];
    logic [31:0] m_rid  [32];
    logic [31:0] m_ctl  [32];
    logic [31:0] m_dlo  [32];
    logic [31:0] m_dhi  [32];

    function automatic bit m_hit(int i, bit ext, logic [28:0] id);
        bit ame = m_filt[i][30];
        if (!(ame && m_mask[i][31]) && (m_filt[i][31] != ext)) return 0;
        if (ext) begin
            for (int b = 0; b < 29; b++)
                if (!(ame && m_mask[i][b]) && id[b] != m_filt[i][b]) return 0;
        end else begin
            for (int b = 0; b < 11; b++)
                if (!(ame && m_mask[i][18+b]) && id[b] != m_filt[i][18+b]) return 0;
        end
        return 1;
    endfunction

    function automatic logic [31:0] m_read(logic [8:0] a);
        int i = int'(a[7:3]);
        if (!a[8]) begin
            case (a[2:0])
                3'd0: return m_en;
                3'd1: return m_dir;
                3'd2: return m_prot;
                3'd3: return m_pend;
                3'd4: return m_lost;
                default: return 32'd0;
            endcase
        end
        case (a[2:0])
            3'd0: return m_filt[i];
            3'd1: return m_mask[i];
            3'd2: return m_rid[i];
            3'd3: return m_ctl[i];
            3'd4: return m_dlo[i];
            3'd5: return m_dhi[i];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [8:0] a);
        if (!a[8]) begin
            if (a[2:0] == 3'd3) return "R7";
            if (a[2:0] == 3'd4) return "R9";
            return "R11";
        end
        if (a[2:0] <= 3'd1) return "R11";
        return "R6";
    endfunction

    // Model update at each rising edge
    always @(posedge clk) begin
        int  tgt;
        bit  ovr;
        int  wi;
        if (!rst_n) begin
            m_en = 0; m_dir = 0; m_prot = 0; m_pend = 0; m_lost = 0;
            for (int i = 0; i < 32; i++) begin
                m_filt[i] = 0; m_mask[i] = 0; m_rid[i] = 0;
                m_ctl[i] = 0; m_dlo[i] = 0; m_dhi[i] = 0;
            end
        end else begin
            tgt = -1;
            ovr = 0;
            if (frm_valid) begin
                for (int i = 31; i >= 0; i--) begin
                    if (m_en[i] && m_dir[i] && m_hit(i, frm_ext, frm_id)) begin
                        if (m_pend[i] && m_prot[i]) continue;
                        tgt = i;
                        ovr = m_pend[i];
                        break;
                    end
                end
            end
            if (reg_we) begin
                wi = int'(reg_addr[7:3]);
                if (!reg_addr[8]) begin
                    case (reg_addr[2:0])
                        3'd0: m_en = reg_wdata;
                        3'd1: m_dir = reg_wdata;
                        3'd2: m_prot = reg_wdata;
                        3'd3: m_pend = m_pend & ~reg_wdata;
                        3'd4: m_lost = m_lost & ~reg_wdata;
                        default: ;
                    endcase
                end else begin
                    if (reg_addr[2:0] == 3'd0) m_filt[wi] = reg_wdata;
                    if (reg_addr[2:0] == 3'd1) m_mask[wi] = reg_wdata;
                end
            end
            if (tgt >= 0) begin
                m_rid[tgt] = frm_ext ? {1'b1, 2'b00, frm_id} : {1'b0, 2'b00, frm_id[10:0], 18'd0};
                m_ctl[tgt] = {27'd0, frm_rtr, frm_dlc};
                m_dlo[tgt] = frm_data[63:32];
                m_dhi[tgt] = frm_data[31:0];
                m_pend[tgt] = 1'b1;
                if (ovr) m_lost[tgt] = 1'b1;
            end
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (reg_rdata !== m_read(reg_addr)) begin
                errors++;
                $display("FAIL %s model compare addr=%h actual=%h expected=%h",
                         tag_of(reg_addr), reg_addr, reg_rdata, m_read(reg_addr));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run-completion actual=%0d cycles expected<%0d", cyc, WDOG_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [8:0] ma(int i, int s);
        return 9'h100 | 9'(i << 3) | 9'(s);
    endfunction

    function automatic logic [8:0] ga(int s);
        return 9'(s);
    endfunction

    task automatic reg_wr(logic [8:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic send(bit ext, bit rtr, logic [28:0] id, logic [3:0] dlc, logic [63:0] d);
        frm_valid = 1'b1; frm_ext = ext; frm_rtr = rtr;
        frm_id = id; frm_dlc = dlc; frm_data = d;
        @(posedge clk); #1;
        frm_valid = 1'b0;
    endtask

    task automatic send_and_clear(logic [28:0] id, logic [31:0] clr);
        frm_valid = 1'b1; frm_ext = 1'b0; frm_rtr = 1'b0;
        frm_id = id; frm_dlc = 4'd3; frm_data = 64'h0102_0300_0000_0000;
        reg_we = 1'b1; reg_addr = ga(3); reg_wdata = clr;
        @(posedge clk); #1;
        frm_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd_chk(logic [8:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        @(negedge clk);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
        end
        #1;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_chk(ga(3), 32'h0, "R1");
        rd_chk(ma(31, 2), 32'h0, "R1");
        rd_chk(ga(6), 32'h0, "R1");

        // Configuration
        reg_wr(ga(0), 32'hF000_002F);
        reg_wr(ga(1), 32'hF000_000F);
        reg_wr(ga(2), 32'h2000_0000);
        reg_wr(ma(31, 0), 32'h81AB_CDE0);
        reg_wr(ma(30, 0), 32'h448C_0000);
        reg_wr(ma(30, 1), 32'h003C_0000);
        reg_wr(ma(29, 0), 32'h4000_0000);
        reg_wr(ma(29, 1), 32'hFFFF_FFFF);
        reg_wr(ma(28, 0), 32'h4000_0000);
        reg_wr(ma(28, 1), 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) begin
            reg_wr(ma(i, 0), 32'h4000_0000);
            reg_wr(ma(i, 1), 32'hFFFF_FFFF);
        end

        // R11: configuration readback
        rd_chk(ma(30, 0), 32'h448C_0000, "R11");
        rd_chk(ga(0), 32'hF000_002F, "R11");

        // R3 R4 R6: standard 0x123 lands in mailbox 30
        send(0, 0, 29'h123, 4'd8, 64'h1122_3344_5566_7788);
        rd_chk(ga(3), 32'h4000_0000, "R3");
        rd_chk(ma(30, 2), 32'h048C_0000, "R4");
        rd_chk(ma(30, 3), 32'h0000_0008, "R6");
        rd_chk(ma(30, 4), 32'h1122_3344, "R6");
        rd_chk(ma(30, 5), 32'h5566_7788, "R6");

        // R9: unprotected overwrite of mailbox 30
        send(0, 0, 29'h12A, 4'd1, 64'hAA00_0000_0000_0000);
        rd_chk(ga(4), 32'h4000_0000, "R9");
        rd_chk(ma(30, 2), 32'h04A8_0000, "R9");

        // R4 R6: extended exact match, remote frame, into mailbox 31
        send(1, 1, 29'h1ABC_DE0, 4'd0, 64'h0);
        rd_chk(ma(31, 2), 32'h81AB_CDE0, "R4");
        rd_chk(ma(31, 3), 32'h0000_0010, "R6");
        rd_chk(ga(3), 32'hC000_0000, "R7");

        // R5: all-ones mask on 29 accepts an extended frame
        send(1, 0, 29'h1ABC_DE1, 4'd4, 64'hDEAD_BEEF_0000_0000);
        rd_chk(ga(3), 32'hE000_0000, "R5");

        // R8: protected pending 29 skipped, frame goes to 28
        send(0, 0, 29'h700, 4'd2, 64'h5A5A_0000_0000_0000);
        rd_chk(ga(3), 32'hF000_0000, "R8");
        rd_chk(ma(29, 2), 32'h81AB_CDE1, "R8");
        rd_chk(ga(4), 32'h4000_0000, "R8");

        // R9: overwrite of unprotected pending 28
        send(0, 0, 29'h701, 4'd2, 64'h0);
        rd_chk(ga(4), 32'h5000_0000, "R9");

        // R7: write-one-to-clear of pending bit 29
        reg_wr(ga(3), 32'h2000_0000);
        rd_chk(ga(3), 32'hD000_0000, "R7");
        send(0, 0, 29'h702, 4'd1, 64'h0);
        rd_chk(ga(3), 32'hF000_0000, "R7");
        rd_chk(ga(4), 32'h5000_0000, "R9");

        // R9: lost clears by writing ones
        reg_wr(ga(4), 32'hFFFF_FFFF);
        rd_chk(ga(4), 32'h0, "R9");

        // R8: clear of 29 in the same cycle does not unprotect it for this frame
        send_and_clear(29'h703, 32'h2000_0000);
        rd_chk(ga(3), 32'hD000_0000, "R8");
        rd_chk(ga(4), 32'h1000_0000, "R8");

        // R7: clear and set of bit 30 in one cycle ends set
        send_and_clear(29'h120, 32'h4000_0000);
        rd_chk(ga(3), 32'hD000_0000, "R7");
        rd_chk(ma(30, 2), 32'h0480_0000, "R7");
        rd_chk(ga(4), 32'h5000_0000, "R9");

        // R5: outside the masked range of 30, falls to free 29
        send(0, 0, 29'h133, 4'd5, 64'h0);
        rd_chk(ga(3), 32'hF000_0000, "R5");
        rd_chk(ma(29, 2), 32'h04CC_0000, "R5");

        // R10 R2: only protected 29 and transmit mailbox 5 enabled: dropped
        reg_wr(ga(0), 32'h2000_0020);
        send(0, 0, 29'h7FF, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(ga(3), 32'hF000_0000, "R10");
        rd_chk(ga(4), 32'h5000_0000, "R10");
        rd_chk(ma(29, 2), 32'h04CC_0000, "R10");
        rd_chk(ma(5, 2), 32'h0, "R2");

        // R11: received-content registers ignore writes
        reg_wr(ma(31, 2), 32'hDEAD_BEEF);
        rd_chk(ma(31, 2), 32'h81AB_CDE0, "R11");

        repeat (2) @(posedge clk);
        #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule